// File: doc/BRIEF.md
# Interleaved Half-Rate Serial Delay Line

This block is a serial-in, serial-out delay line of `DEPTH` stages. It behaves exactly like an ordinary shift register clocked every cycle: each sample leaves the block `DEPTH` cycles after it entered. Inside, the storage is divided into `LANES` separate chains of `DEPTH/LANES` stages each. A phase counter picks one chain per cycle, and only that chain loads the incoming sample and advances. Every chain therefore moves once every `LANES` cycles, so each runs at a fraction of the input rate.

An output selector reads the last stage of the chain that the phase counter points to. In that cycle, that stage holds the sample that is now due. The chains share the one block clock. The reduced rate comes only from load enables, and no divided clock is used. `LANES` may be 1, which gives a plain single chain, 2, which is the default, or 4. Each sample is `DATA_W` bits wide.

Top module: `interleaved_shift_reg`

## Requirements
- R1: With the default two lanes, `dout_o` in any cycle equals the `din_i` value sampled `DEPTH` rising edges earlier, once at least `DEPTH` samples have entered since reset.
- R2: During the first `DEPTH` cycles after reset is released, `dout_o` is all zeros, whatever is driven on `din_i`.
- R3: The lane phase is 0 right after reset and advances by one lane per cycle, wrapping from `LANES-1` to 0. The `DEPTH`-cycle delay therefore stays exact whichever phase the stream was in when reset was applied.
- R4: In each cycle exactly one lane loads the input sample and advances. Every other lane keeps its contents, so a single non-zero sample shows up at the output in exactly one cycle.
- R5: A synchronous reset (`rst_i` high at a rising edge) clears every lane. No sample that entered before the reset ever appears at the output afterwards.
- R6: With `LANES` = 1 the block is a plain single chain with the same `DEPTH`-cycle delay.
- R7: With `LANES` = 4 the delay is still exactly `DEPTH` cycles.
- R8: All `DATA_W` bits of a sample travel together, and each bit appears at the output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock. Sampled on the rising edge. |
| rst_i | input | 1 | Synchronous reset, active high. Clears the lanes and the phase. |
| din_i | input | DATA_W | Serial input sample, captured every cycle. |
| dout_o | output | DATA_W | Serial output: the input sample from `DEPTH` cycles earlier. |

## Verification
Three configurations are driven: two lanes with a one-bit sample, one lane, and four lanes with a three-bit sample. Each is compared against a plain shift-register model, both over a fixed pattern table and over random data.

- **Single-pulse input.** A lone pulse catches a lane that advances when it was not loaded: such a design would smear the pulse or drop it.
- **Reset on an odd or even phase.** A design that does not restart the phase at lane 0 would read the wrong lane after the reset, and its output would come out shifted by a cycle or scrambled.
- **Reset with all-ones data stored.** A design that failed to clear every lane would let old ones leak out after the reset.
- **Fill window.** A wrong selector index or a wrong stage count shows up as an output that is off by one cycle.

// File: rtl/hrsr_pkg.sv
package hrsr_pkg;

   // Width of the lane-select phase; at least one bit even for a single lane.
   function automatic int sel_width(input int lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction

   // Width of a saturating counter that must reach the value n.
   function automatic int count_width(input int n);
      return (n > 1) ? $clog2(n + 1) : 1;
   endfunction

endpackage

// File: rtl/hrsr_phase.sv
module hrsr_phase #(
   parameter int LANES = 2,
   parameter int SEL_W = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [SEL_W-1:0] sel_o,
   output logic [LANES-1:0] load_o
);

   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(LANES - 1);

   logic [SEL_W-1:0] sel_q;

   // Round-robin phase: restarts at lane 0 on reset, wraps after the last lane.
   always_ff @(posedge clk_i) begin
      if (rst_i || sel_q == LAST_SEL) begin
         sel_q <= '0;
      end else begin
         sel_q <= sel_q + SEL_W'(1);
      end
   end

   assign sel_o = sel_q;

   // One load enable per lane, decoded from the phase.
   for (genvar k = 0; k < LANES; k++) begin : g_load
      assign load_o[k] = (sel_q == SEL_W'(k));
   end

   p_phase_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_q != LAST_SEL) |=> (sel_q == $past(sel_q) + SEL_W'(1)));

   p_phase_wrap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_q == LAST_SEL) |=> (sel_q == '0));

   p_phase_reset_r3: assert property (@(posedge clk_i)
      rst_i |=> (sel_q == '0));

endmodule

// File: rtl/hrsr_lane.sv
module hrsr_lane #(
   parameter int DATA_W = 1,
   parameter int STAGES = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] tail_o
);

   logic [STAGES-1:0][DATA_W-1:0] stage_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            stage_q <= '0;
         end else if (load_i) begin
            stage_q[0] <= din_i;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            stage_q <= '0;
         end else if (load_i) begin
            stage_q <= {stage_q[STAGES-2:0], din_i};
         end
      end
   end

   assign tail_o = stage_q[STAGES-1];

   p_load_capture_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> (stage_q[0] == $past(din_i)));

   p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_i |=> $stable(stage_q));

   p_reset_clear_r5: assert property (@(posedge clk_i)
      rst_i |=> (stage_q == '0));

endmodule

// File: rtl/hrsr_outmux.sv
module hrsr_outmux #(
   parameter int DATA_W = 1,
   parameter int LANES  = 2,
   parameter int SEL_W  = 1
) (
   input  logic [LANES-1:0][DATA_W-1:0] tails_i,
   input  logic [SEL_W-1:0]             sel_i,
   output logic [DATA_W-1:0]            dout_o
);

   // AND-OR selector: balanced depth, no out-of-range index.
   always_comb begin
      dout_o = '0;
      for (int k = 0; k < LANES; k++) begin
         if (sel_i == SEL_W'(k)) begin
            dout_o = dout_o | tails_i[k];
         end
      end
   end

endmodule

// File: rtl/interleaved_shift_reg.sv
module interleaved_shift_reg #(
   parameter int DEPTH  = 16,
   parameter int LANES  = 2,
   parameter int DATA_W = 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);

   localparam int SEL_W  = hrsr_pkg::sel_width(LANES);
   localparam int STAGES = (LANES > 0) ? DEPTH / LANES : 1;
   localparam int CNT_W  = hrsr_pkg::count_width(DEPTH);
   localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(DEPTH);

   if (!(LANES == 1 || LANES == 2 || LANES == 4)) begin : g_bad_lanes
      $error("interleaved_shift_reg: LANES must be 1, 2 or 4");
   end
   if (DEPTH < LANES || (DEPTH % LANES) != 0) begin : g_bad_depth
      $error("interleaved_shift_reg: DEPTH must be a non-zero multiple of LANES");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("interleaved_shift_reg: DATA_W must be at least 1");
   end

   logic [SEL_W-1:0]             sel;
   logic [LANES-1:0]             load_en;
   logic [LANES-1:0][DATA_W-1:0] tails;

   hrsr_phase #(
      .LANES (LANES),
      .SEL_W (SEL_W)
   ) u_phase (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .sel_o  (sel),
      .load_o (load_en)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      hrsr_lane #(
         .DATA_W (DATA_W),
         .STAGES (STAGES)
      ) u_lane (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .load_i (load_en[k]),
         .din_i  (din_i),
         .tail_o (tails[k])
      );
   end

   hrsr_outmux #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .SEL_W  (SEL_W)
   ) u_outmux (
      .tails_i (tails),
      .sel_i   (sel),
      .dout_o  (dout_o)
   );

   // Samples entered since reset, saturating at DEPTH; used by the checks below.
   logic [CNT_W-1:0] fill_q;
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         fill_q <= '0;
      end else if (fill_q != FILL_MAX) begin
         fill_q <= fill_q + CNT_W'(1);
      end
   end

   p_early_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (fill_q != FILL_MAX) |-> (dout_o == '0));

   p_one_lane_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(load_en) == 1);

endmodule

// File: tb/test_interleaved_shift_reg.sv
module test_interleaved_shift_reg;

   localparam int CLK_PERIOD = 10;
   localparam int D_A = 16;
   localparam int D_C = 8;
   localparam int NSTIM = 40;
   // bit 3 feeds the one-bit instances, bits 2:0 feed the three-bit instance
   localparam logic [3:0] STIM [NSTIM] = '{
      4'h9, 4'h2, 4'hF, 4'h0, 4'h6, 4'hB, 4'h1, 4'h8, 4'hC, 4'h3,
      4'h7, 4'hE, 4'h5, 4'hA, 4'h4, 4'hD, 4'h0, 4'hF, 4'h8, 4'h1,
      4'h2, 4'hB, 4'h6, 4'h9, 4'hE, 4'h3, 4'hC, 4'h5, 4'hA, 4'h7,
      4'h1, 4'hD, 4'h4, 4'h8, 4'hF, 4'h0, 4'h6, 4'hB, 4'h2, 4'h9
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       din_a = 1'b0;
   logic [2:0] din_c = '0;
   logic       dout_a, dout_b;
   logic [2:0] dout_c;

   int checks = 0;
   int failures = 0;

   logic       ref_a [D_A];
   logic [2:0] ref_c [D_C];
   int fill_a = 0;
   int fill_c = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   interleaved_shift_reg #(.DEPTH(D_A), .LANES(2), .DATA_W(1)) i_interleaved_shift_reg (
      .clk_i(clk), .rst_i(rst), .din_i(din_a), .dout_o(dout_a));

   interleaved_shift_reg #(.DEPTH(D_A), .LANES(1), .DATA_W(1)) i_interleaved_shift_reg_l1 (
      .clk_i(clk), .rst_i(rst), .din_i(din_a), .dout_o(dout_b));

   interleaved_shift_reg #(.DEPTH(D_C), .LANES(4), .DATA_W(3)) i_interleaved_shift_reg_l4 (
      .clk_i(clk), .rst_i(rst), .din_i(din_c), .dout_o(dout_c));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_refs();
      for (int i = 0; i < D_A; i++) ref_a[i] = 1'b0;
      for (int i = 0; i < D_C; i++) ref_c[i] = 3'b000;
      fill_a = 0;
      fill_c = 0;
   endtask

   // Called at a falling edge: check the outputs, then drive the next inputs.
   task automatic step(input logic r, input logic a, input logic [2:0] c, input string tag);
      string ta;
      string tc;
      ta = (fill_a < D_A) ? "R2" : tag;
      tc = (fill_c < D_C) ? "R2" : tag;
      chk(ta, {7'd0, dout_a}, {7'd0, ref_a[D_A-1]});
      chk({ta, " R6"}, {7'd0, dout_b}, {7'd0, ref_a[D_A-1]});
      chk({tc, " R7 R8"}, {5'd0, dout_c}, {5'd0, ref_c[D_C-1]});
      rst = r;
      din_a = a;
      din_c = c;
      if (r) begin
         clear_refs();
      end else begin
         for (int i = D_A - 1; i > 0; i--) ref_a[i] = ref_a[i-1];
         ref_a[0] = a;
         for (int i = D_C - 1; i > 0; i--) ref_c[i] = ref_c[i-1];
         ref_c[0] = c;
         if (fill_a < D_A) fill_a++;
         if (fill_c < D_C) fill_c++;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      clear_refs();
      rst = 1'b1;
      din_a = 1'b1;
      din_c = 3'b111;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state
      chk("R5 reset", {7'd0, dout_a}, 8'd0);
      chk("R5 reset", {5'd0, dout_c}, 8'd0);

      // pattern table, R1 (R2 while filling)
      for (int i = 0; i < NSTIM; i++) step(1'b0, STIM[i][3], STIM[i][2:0], "R1");

      // single pulse through quiet lanes, R4
      step(1'b1, 1'b0, 3'b000, "R4");
      for (int i = 0; i < 40; i++)
         step(1'b0, (i == 5) ? 1'b1 : 1'b0, (i == 5) ? 3'b101 : 3'b000, "R4");
      for (int i = 0; i < 40; i++)
         step(1'b0, (i == 6) ? 1'b1 : 1'b0, (i == 6) ? 3'b010 : 3'b000, "R4");

      // mid-stream reset with all lanes full of ones, R5
      for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 3'b111, "R5");
      step(1'b1, 1'b1, 3'b111, "R5");
      for (int i = 0; i < 24; i++) step(1'b0, 1'b0, 3'b000, "R5");

      // reset landing on odd then even phases, R3
      for (int n = 0; n < 4; n++) begin
         for (int i = 0; i < 7 + n; i++) step(1'b0, 1'($urandom), 3'($urandom), "R3");
         step(1'b1, 1'($urandom), 3'($urandom), "R3");
         for (int i = 0; i < 30; i++) step(1'b0, 1'($urandom), 3'($urandom), "R3");
      end

      // long random stream, R1
      for (int i = 0; i < 400; i++) step(1'b0, 1'($urandom), 3'($urandom), "R1");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule